// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns three asynchronous interrupt pins into latched request flags for an interrupt resolver. The pins are one non-maskable source and two general sources. Each pin passes through a synchronizer and then an edge or level detector. A write-only mode byte chooses how each source is detected. The non-maskable source always fires on a falling edge, and it can also be set to fire on rising edges. Each general source can be edge-triggered or level-sensitive, and its polarity can be chosen.

Software clears a latched request by writing that source's vector code to a separate clear location. The code must fit in six bits. A request can also be dropped by a one-cycle acknowledge pulse from the interrupt controller. The block drives an enable for the key-on wakeup logic, which sits outside it. That enable is forced low while the second general source is level-sensitive.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every request output is 0, every mode field is 0, and `keyon_en` is 1.
- R2: While mode bit 0 is 0, the non-maskable request (`irq_req[0]`) sets on a falling pin edge only. A rising edge has no effect.
- R3: While mode bit 0 is 1, `irq_req[0]` sets on both rising and falling pin edges.
- R4: While mode bit 1 is 0, `irq_req[1]` is edge-triggered. The edge is rising when mode bit 2 is 0 and falling when mode bit 2 is 1. The opposite edge is ignored.
- R5: While mode bit 1 is 1, `irq_req[1]` follows the pin level. The pin is active-high when mode bit 2 is 0 and active-low when it is 1. A clear write has no lasting effect while the active level is present.
- R6: Mode bits 3 and 4 control `irq_req[2]` in the same way that bits 1 and 2 control `irq_req[1]`.
- R7: With the default two-stage synchronizer, a pin change made between clock edges shows on the request output after the third rising clock edge that follows it, and not before.
- R8: A write of the byte {2'b00, code} to `CLR_ADDR` clears the matching edge-mode request one cycle later. The default codes are 0x08 for the non-maskable source, 0x0A for `irq_req[1]` and 0x0B for `irq_req[2]`.
- R9: A clear write whose byte matches no source code leaves every request unchanged.
- R10: When a detected edge falls in the same cycle as a matching clear write, the edge wins and the request stays set.
- R11: A one-cycle pulse on `irq_ack[i]` clears edge-mode request i on the next clock edge.
- R12: `keyon_en` is 0 while mode bit 3 is 1 and 1 while it is 0. It follows each mode write one cycle after the write.
- R13: Mode bits 7 to 5 are ignored. A mode byte of 0xE0 behaves exactly like a mode byte of 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_nmi | input | 1 | Asynchronous non-maskable interrupt pin |
| pin_int0 | input | 1 | Asynchronous general interrupt pin 0 |
| pin_int1 | input | 1 | Asynchronous general interrupt pin 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address (mode or clear) |
| wr_data | input | 8 | Register write data |
| irq_ack | input | 3 | Per-source acknowledge pulse (bit 0 non-maskable, 1 int0, 2 int1) |
| irq_req | output | 3 | Latched request flags, same bit order |
| keyon_en | output | 1 | Key-on wakeup enable, low while int1 is level-sensitive |

## Verification
The assertions assume that the pins are held low while reset is asserted. Otherwise the synchronizer, which resets to zero, would see a first rising edge that the pin never made. They also assume that a write strobe lasts one cycle and carries a single address. The stimulus keeps all three pins low through reset and changes each pin only between clock edges. It then holds each pin level for at least four cycles, so that every edge fully crosses the synchronizer before the next one. Every write is a single-cycle pulse issued away from the active edge.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_NMI  = 0;
  localparam int SRC_INT0 = 1;
  localparam int SRC_INT1 = 2;
  localparam int CODE_W   = 6;

  // per-source detection choice
  typedef struct packed {
    logic level;    // 1: level-sensitive
    logic falling;  // 1: falling edge / active-low
    logic both;     // 1: either edge
  } src_cfg_t;

  // stored mode fields (upper write bits are discarded)
  typedef struct packed {
    logic i1_fall;
    logic i1_level;
    logic i0_fall;
    logic i0_level;
    logic nmi_both;
  } mode_t;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= pin_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign sync_o = stg[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/eic_detect.sv
module eic_detect
  import eic_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cur_i,
  input  logic     prev_i,
  input  src_cfg_t cfg_i,
  input  logic     clr_i,
  input  logic     ack_i,
  output logic     flag_o
);
  logic active, rise, fall, hit, flag_q;

  always_comb begin
    active = cfg_i.falling ? ~cur_i : cur_i;
    rise   = cur_i & ~prev_i;
    fall   = ~cur_i & prev_i;
    if (cfg_i.both)         hit = rise | fall;
    else if (cfg_i.falling) hit = fall;
    else                    hit = rise;
  end

  always_ff @(posedge clk) begin
    if (rst)              flag_q <= 1'b0;
    else if (cfg_i.level) flag_q <= active;
    else                  flag_q <= hit | (flag_q & ~clr_i & ~ack_i);
  end

  assign flag_o = flag_q;

  // edge mode: a set flag with no clear/ack stays set
  assert_edge_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_i.level && flag_q && !clr_i && !ack_i) |=> flag_q);

  // edge mode: clear or ack without a new edge drops the flag
  assert_clear_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (!cfg_i.level && (clr_i || ack_i) && !hit) |=> !flag_q);

  // edge mode: an edge arriving with a clear still leaves the flag set
  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (!cfg_i.level && hit) |=> flag_q);

  // level mode: flag tracks the active level one cycle later
  assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_i.level |=> (flag_q == $past(active)));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int              ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 4'h1,
  parameter logic [5:0]      VEC_NMI     = 6'h08,
  parameter logic [5:0]      VEC_INT0    = 6'h0A,
  parameter logic [5:0]      VEC_INT1    = 6'h0B,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_nmi,
  input  logic              pin_int0,
  input  logic              pin_int1,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NSRC-1:0]   irq_ack,
  output logic [NSRC-1:0]   irq_req,
  output logic              keyon_en
);
  localparam logic [NSRC*CODE_W-1:0] CODES = {VEC_INT1, VEC_INT0, VEC_NMI};

  mode_t           mode_q;
  logic [NSRC-1:0] cur, prev, clr_hit;
  src_cfg_t        cfg [NSRC];

  wire mode_wr = wr_en && (wr_addr == MODE_ADDR);
  wire clr_wr  = wr_en && (wr_addr == CLR_ADDR);

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= wr_data[4:0];
  end

  assign keyon_en = ~mode_q.i1_level;

  always_comb begin
    cfg[SRC_NMI]  = '{level: 1'b0, falling: 1'b1, both: mode_q.nmi_both};
    cfg[SRC_INT0] = '{level: mode_q.i0_level, falling: mode_q.i0_fall, both: 1'b0};
    cfg[SRC_INT1] = '{level: mode_q.i1_level, falling: mode_q.i1_fall, both: 1'b0};
  end

  eic_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .pin_i({pin_int1, pin_int0, pin_nmi}),
    .sync_o(cur), .prev_o(prev)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign clr_hit[i] = clr_wr &&
      (wr_data == {2'b00, CODES[i*CODE_W +: CODE_W]});
    eic_detect u_det (
      .clk(clk), .rst(rst),
      .cur_i(cur[i]), .prev_i(prev[i]), .cfg_i(cfg[i]),
      .clr_i(clr_hit[i]), .ack_i(irq_ack[i]),
      .flag_o(irq_req[i])
    );
  end

  // wakeup enable must drop after a write that makes int1 level-sensitive
  assert_keyon_low_R12: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && wr_data[3]) |=> !keyon_en);

  assert_keyon_high_R12: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !wr_data[3]) |=> keyon_en);

  // at most one source can match one clear byte
  assert_one_match_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_hit));
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  logic       clk = 0, rst = 1;
  logic       pin_nmi = 0, pin_int0 = 0, pin_int1 = 0;
  logic       wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] irq_ack = 0;
  logic [2:0] irq_req;
  logic       keyon_en;

  localparam logic [3:0] MODE = 4'h0, CLR = 4'h1;

  ext_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .pin_nmi(pin_nmi), .pin_int0(pin_int0),
    .pin_int1(pin_int1), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_ack(irq_ack), .irq_req(irq_req),
    .keyon_en(keyon_en)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct { int cyc; logic [3:0] v; string tag; } item_t;
  item_t q[$];
  int cnt = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cnt <= cnt + 1;

  // monitor: compare {keyon_en, irq_req} against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cnt) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if ({keyon_en, irq_req} !== it.v) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", it.tag, {keyon_en, irq_req}, it.v);
      end
    end
  end

  task automatic nxt(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic expect_at(int d, logic [3:0] v, string tag);
    item_t it;
    it.cyc = cnt + d; it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    nxt();
    wr_en = 0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: got hang expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(posedge clk);
    #1 rst = 0;
    nxt();
    expect_at(0, 4'b1000, "R1 reset state");
    nxt(2);

    // R2: rising ignored, falling detected
    pin_nmi = 1; expect_at(3, 4'b1000, "R2 rising ignored"); nxt(4);
    pin_nmi = 0;
    expect_at(2, 4'b1000, "R7 not before third edge");
    expect_at(3, 4'b1001, "R2 R7 falling sets");
    nxt(4);
    expect_at(1, 4'b1000, "R8 clear nmi 0x08"); wr(CLR, 8'h08); nxt();

    // R4 rising default, R9 non-matching clear
    pin_int0 = 1; expect_at(3, 4'b1010, "R4 rising sets"); nxt(4);
    expect_at(1, 4'b1010, "R9 other code"); wr(CLR, 8'h0B);
    expect_at(1, 4'b1010, "R9 unused code"); wr(CLR, 8'h3F);
    expect_at(1, 4'b1010, "R9 upper bits set"); wr(CLR, 8'h4A);
    expect_at(1, 4'b1000, "R8 clear int0 0x0A"); wr(CLR, 8'h0A);
    pin_int0 = 0; expect_at(3, 4'b1000, "R4 falling ignored"); nxt(4);

    // R4 falling polarity, R11 ack
    wr(MODE, 8'h04);
    pin_int0 = 1; expect_at(3, 4'b1000, "R4 rising ignored in falling mode"); nxt(4);
    pin_int0 = 0; expect_at(3, 4'b1010, "R4 falling sets"); nxt(4);
    irq_ack = 3'b010; expect_at(1, 4'b1000, "R11 ack clears"); nxt(); irq_ack = 0;

    // R10 edge with clear in same cycle
    pin_int0 = 1; nxt(4);
    pin_int0 = 0; nxt(2);
    expect_at(1, 4'b1010, "R10 edge wins over clear"); wr(CLR, 8'h0A);
    expect_at(1, 4'b1000, "R8 clear after"); wr(CLR, 8'h0A);

    // R5 level active-high then active-low
    wr(MODE, 8'h02);
    pin_int0 = 1; expect_at(3, 4'b1010, "R5 level high"); nxt(4);
    expect_at(1, 4'b1010, "R5 clear no effect"); wr(CLR, 8'h0A);
    expect_at(1, 4'b1010, "R5 still set after clear"); nxt();
    pin_int0 = 0; expect_at(3, 4'b1000, "R5 follows level low"); nxt(4);
    expect_at(2, 4'b1010, "R5 active-low"); wr(MODE, 8'h06); nxt(3);
    wr(MODE, 8'h00); nxt();
    expect_at(1, 4'b1000, "R8 clear int0"); wr(CLR, 8'h0A);

    // R6 int1, R12 keyon
    pin_int1 = 1; expect_at(3, 4'b1100, "R6 int1 rising"); nxt(4);
    expect_at(1, 4'b1000, "R8 clear int1 0x0B"); wr(CLR, 8'h0B);
    expect_at(1, 4'b0000, "R12 keyon low in level"); wr(MODE, 8'h18); nxt(2);
    pin_int1 = 0; expect_at(3, 4'b0100, "R6 level active-low"); nxt(4);
    pin_int1 = 1; expect_at(3, 4'b0000, "R6 level released"); nxt(4);
    expect_at(1, 4'b1000, "R12 keyon back high"); wr(MODE, 8'h00); nxt();

    // R3 both edges
    wr(MODE, 8'h01);
    pin_nmi = 1; expect_at(3, 4'b1001, "R3 rising sets"); nxt(4);
    expect_at(1, 4'b1000, "R8 clear nmi"); wr(CLR, 8'h08);
    pin_nmi = 0; expect_at(3, 4'b1001, "R3 falling sets"); nxt(4);
    expect_at(1, 4'b1000, "R8 clear nmi"); wr(CLR, 8'h08);

    // R13 upper mode bits ignored
    wr(MODE, 8'hE0);
    pin_nmi = 1; pin_int0 = 1;
    expect_at(3, 4'b1010, "R13 upper bits ignored"); nxt(4);
    pin_nmi = 0; expect_at(3, 4'b1011, "R13 nmi falling only"); nxt(4);

    nxt(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule